// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 34-bit physical address. It walks a two-level table of 4-byte entries held in memory, starting from the root page number supplied on a configuration input. A requester presents the virtual address together with the kind of access (load, store or instruction fetch), the privilege of the access, and two permission-relaxing flags. One flag lets supervisor code touch user pages. The other lets loads read pages that are marked execute-only. The walker reads one entry per level, validates it, and answers with either a physical address and the leaf's permissions or a page fault.

The accessed and dirty flags of a leaf entry can be handled in two ways, chosen by a configuration input. In the first, a missing flag raises a fault. In the second, the walker writes the entry back with the flags set. During that write-back it holds a lock line toward memory from the first entry read until the write completes, so the read and the update form one atomic sequence. Only one request is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: Each entry address is the table page number followed by a 10-bit index and two zero bits. The first read uses the root page number and VA[31:22]. A second read uses the page number of the pointer entry and VA[21:12]. Entry layout: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 user, bit 6 accessed, bit 7 dirty, bits 31:10 page number, of which bits 19:10 are the low part.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. A read request (`mem_req_valid` high, `mem_req_we` low) follows in the next cycle. `req_ready` stays low from acceptance until the response cycle. Every memory request is a one-cycle pulse.
- R3: An entry whose valid bit is 0, or whose read bit is 0 while its write bit is 1, ends the walk with a fault.
- R4: An entry with read, write and execute all 0 is a pointer. At the first level it starts the second read. At the second level it is a fault.
- R5: Access encoding is 0 for load, 1 for store and 2 for fetch. A load needs the read bit, or the execute bit when `req_mxr` is 1. A store needs the write bit. A fetch needs the execute bit. Anything else faults.
- R6: A user access (`req_user`=1) needs the user bit set. A supervisor access to a page whose user bit is set faults unless `req_sum` is 1.
- R7: A first-level leaf faults if its low page-number field is nonzero. Otherwise the physical address is {entry[31:20], VA[21:0]}. A second-level leaf gives {entry[31:10], VA[11:0]}.
- R8: With `cfg_hw_ad`=0, a leaf that lacks the accessed bit, or a store to a leaf that lacks the dirty bit, faults and causes no memory write.
- R9: With `cfg_hw_ad`=1, the same case causes exactly one write to the entry's own address. The written entry has the accessed bit set, and also the dirty bit for a store. `mem_lock` is high for every memory access of the walk. The walk then succeeds.
- R10: `rsp_valid` is high for exactly one cycle per request. On success it carries the address and the leaf's {execute, write, read} bits. On a fault, `rsp_paddr` and `rsp_perm` are zero.
- R11: When memory answers in the cycle after each request, the response arrives 3 cycles after acceptance for each entry read, plus 2 cycles for a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | Access made at user privilege |
| req_sum | input | 1 | Supervisor may use user pages |
| req_mxr | input | 1 | Loads may read execute-only pages |
| cfg_root_ppn | input | 22 | Page number of the root table |
| cfg_hw_ad | input | 1 | 1: write back accessed/dirty, 0: fault |
| mem_req_valid | output | 1 | One-cycle memory request pulse |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 34 | Entry byte address |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_lock | output | 1 | Memory must keep the walked entries atomic |
| mem_rsp_valid | input | 1 | Memory answer for the last request |
| mem_rsp_rdata | input | 32 | Entry value read |
| rsp_valid | output | 1 | Translation result present |
| rsp_fault | output | 1 | Page fault |
| rsp_paddr | output | 34 | Physical address |
| rsp_perm | output | 3 | Leaf execute, write, read bits |

## Verification
The bench memory answers each pulse on the next edge. With that memory, every result is due a known number of cycles after acceptance: three for each entry read and two more for a write-back. The scoreboard records the cycle of acceptance. It samples the response on the falling edge at which `rsp_valid` is high and checks the elapsed count, as well as the fault flag, address and permissions. At the same sampling point it compares the number of memory writes in the walk and the written entry value against the prediction. It also checks that the response pulse has dropped one cycle later.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_UPDATE,
    ST_DONE
  } walk_st_e;

  // flag positions inside an entry
  localparam int F_V = 0;
  localparam int F_R = 1;
  localparam int F_W = 2;
  localparam int F_X = 3;
  localparam int F_U = 4;
  localparam int F_A = 6;
  localparam int F_D = 7;

endpackage

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             f_v,
  input  logic             f_r,
  input  logic             f_w,
  input  logic             f_x,
  input  logic             f_u,
  input  logic             f_a,
  input  logic             f_d,
  input  logic [IDX_W-1:0] ppn_lo,
  input  logic             lvl_top,
  input  acc_e             acc,
  input  logic             user,
  input  logic             sum,
  input  logic             mxr,
  output logic             invalid,
  output logic             pointer,
  output logic             perm_ok,
  output logic             misaligned,
  output logic             needs_ad
);

  logic type_ok;
  logic priv_ok;

  always_comb begin
    invalid = !f_v || (!f_r && f_w);
    pointer = !f_r && !f_w && !f_x;
    case (acc)
      ACC_LOAD:  type_ok = f_r || (mxr && f_x);
      ACC_STORE: type_ok = f_w;
      ACC_FETCH: type_ok = f_x;
      default:   type_ok = 1'b0;
    endcase
    priv_ok    = user ? f_u : (!f_u || sum);
    perm_ok    = type_ok && priv_ok;
    misaligned = lvl_top && (ppn_lo != '0);
    needs_ad   = !f_a || ((acc == ACC_STORE) && !f_d);
  end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int IDX_W  = 10,
  parameter int ENT_SH = 2,
  parameter int PPN_W  = 22,
  localparam int OFF_W = IDX_W + ENT_SH,
  localparam int VLO_W = IDX_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] ent_tbl,
  input  logic [IDX_W-1:0] ent_idx,
  output logic [PA_W-1:0]  ent_addr,
  input  logic [PPN_W-1:0] leaf_ppn,
  input  logic [VLO_W-1:0] leaf_vlo,
  input  logic             leaf_top,
  output logic [PA_W-1:0]  leaf_pa
);

  always_comb begin
    ent_addr = {ent_tbl, ent_idx, {ENT_SH{1'b0}}};
    if (leaf_top)
      leaf_pa = {leaf_ppn[PPN_W-1:IDX_W], leaf_vlo};
    else
      leaf_pa = {leaf_ppn, leaf_vlo[OFF_W-1:0]};
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W  = 10,
  parameter int ENT_SH = 2,
  parameter int PPN_W  = 22,
  localparam int OFF_W = IDX_W + ENT_SH,
  localparam int VA_W  = 2 * IDX_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int PTE_W = 8 << ENT_SH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic             req_user,
  input  logic             req_sum,
  input  logic             req_mxr,
  input  logic [PPN_W-1:0] cfg_root_ppn,
  input  logic             cfg_hw_ad,
  output logic             mem_req_valid,
  output logic             mem_req_we,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  output logic             mem_lock,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_rdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_perm
);

  import ptw_pkg::*;

  localparam int VLO_W = IDX_W + OFF_W;

  walk_st_e          st;
  logic [VLO_W-1:0]  va_q;
  acc_e              acc_q;
  logic              user_q, sum_q, mxr_q;
  logic              lvl_q;
  logic [PTE_W-1:0]  pte_q;
  logic [PPN_W-1:0]  pte_ppn;
  logic [PPN_W-1:0]  tbl_sel;
  logic [IDX_W-1:0]  idx_sel;
  logic [PA_W-1:0]   ent_addr;
  logic [PA_W-1:0]   leaf_pa;
  logic [PTE_W-1:0]  ad_bits;

  logic              mem_valid_q, mem_we_q;
  logic [PA_W-1:0]   mem_addr_q;
  logic [PTE_W-1:0]  mem_wdata_q;
  logic              rsp_fault_q;
  logic [PA_W-1:0]   rsp_pa_q;
  logic [2:0]        rsp_perm_q;

  logic e_invalid, e_pointer, e_perm_ok, e_misaligned, e_needs_ad;

  assign pte_ppn = pte_q[PTE_W-1 -: PPN_W];
  assign tbl_sel = (st == ST_IDLE) ? cfg_root_ppn : pte_ppn;
  assign idx_sel = (st == ST_IDLE) ? req_vaddr[VA_W-1 -: IDX_W] : va_q[OFF_W +: IDX_W];

  always_comb begin
    ad_bits = '0;
    ad_bits[F_A] = 1'b1;
    if (acc_q == ACC_STORE) ad_bits[F_D] = 1'b1;
  end

  ptw_addr_gen #(
    .IDX_W (IDX_W),
    .ENT_SH(ENT_SH),
    .PPN_W (PPN_W)
  ) u_agen (
    .ent_tbl (tbl_sel),
    .ent_idx (idx_sel),
    .ent_addr(ent_addr),
    .leaf_ppn(pte_ppn),
    .leaf_vlo(va_q),
    .leaf_top(lvl_q),
    .leaf_pa (leaf_pa)
  );

  ptw_entry_check #(
    .IDX_W(IDX_W)
  ) u_echk (
    .f_v       (pte_q[F_V]),
    .f_r       (pte_q[F_R]),
    .f_w       (pte_q[F_W]),
    .f_x       (pte_q[F_X]),
    .f_u       (pte_q[F_U]),
    .f_a       (pte_q[F_A]),
    .f_d       (pte_q[F_D]),
    .ppn_lo    (pte_q[PTE_W-PPN_W +: IDX_W]),
    .lvl_top   (lvl_q),
    .acc       (acc_q),
    .user      (user_q),
    .sum       (sum_q),
    .mxr       (mxr_q),
    .invalid   (e_invalid),
    .pointer   (e_pointer),
    .perm_ok   (e_perm_ok),
    .misaligned(e_misaligned),
    .needs_ad  (e_needs_ad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      va_q        <= '0;
      acc_q       <= ACC_LOAD;
      user_q      <= 1'b0;
      sum_q       <= 1'b0;
      mxr_q       <= 1'b0;
      lvl_q       <= 1'b0;
      pte_q       <= '0;
      mem_valid_q <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      rsp_fault_q <= 1'b0;
      rsp_pa_q    <= '0;
      rsp_perm_q  <= '0;
    end else begin
      mem_valid_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q        <= req_vaddr[VLO_W-1:0];
            acc_q       <= acc_e'(req_acc);
            user_q      <= req_user;
            sum_q       <= req_sum;
            mxr_q       <= req_mxr;
            lvl_q       <= 1'b1;
            mem_valid_q <= 1'b1;
            mem_we_q    <= 1'b0;
            mem_addr_q  <= ent_addr;
            st          <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_rsp_valid) begin
            pte_q <= mem_rsp_rdata;
            st    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (e_invalid || (e_pointer && !lvl_q) ||
              (!e_pointer && (!e_perm_ok || e_misaligned || (e_needs_ad && !cfg_hw_ad)))) begin
            rsp_fault_q <= 1'b1;
            rsp_pa_q    <= '0;
            rsp_perm_q  <= '0;
            st          <= ST_DONE;
          end else if (e_pointer) begin
            lvl_q       <= 1'b0;
            mem_valid_q <= 1'b1;
            mem_we_q    <= 1'b0;
            mem_addr_q  <= ent_addr;
            st          <= ST_READ;
          end else if (e_needs_ad) begin
            mem_valid_q <= 1'b1;
            mem_we_q    <= 1'b1;
            mem_wdata_q <= pte_q | ad_bits;
            st          <= ST_UPDATE;
          end else begin
            rsp_fault_q <= 1'b0;
            rsp_pa_q    <= leaf_pa;
            rsp_perm_q  <= {pte_q[F_X], pte_q[F_W], pte_q[F_R]};
            st          <= ST_DONE;
          end
        end
        ST_UPDATE: begin
          if (mem_rsp_valid) begin
            rsp_fault_q <= 1'b0;
            rsp_pa_q    <= leaf_pa;
            rsp_perm_q  <= {pte_q[F_X], pte_q[F_W], pte_q[F_R]};
            st          <= ST_DONE;
          end
        end
        ST_DONE: begin
          mem_we_q <= 1'b0;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = mem_valid_q;
  assign mem_req_we    = mem_we_q;
  assign mem_req_addr  = mem_addr_q;
  assign mem_req_wdata = mem_wdata_q;
  assign mem_lock      = (st == ST_READ) || (st == ST_CHECK) || (st == ST_UPDATE);
  assign rsp_valid     = (st == ST_DONE);
  assign rsp_fault     = rsp_fault_q;
  assign rsp_paddr     = rsp_pa_q;
  assign rsp_perm      = rsp_perm_q;

  AST_ACCEPT_ISSUES_READ: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> (mem_req_valid && !mem_req_we)); // R2
  AST_MEM_PULSE: assert property (@(posedge clk) disable iff (rst) mem_req_valid |=> !mem_req_valid); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) mem_lock |-> !req_ready); // R2
  AST_WB_SETS_ACCESSED: assert property (@(posedge clk) disable iff (rst) (mem_req_valid && mem_req_we) |-> mem_req_wdata[F_A]); // R9
  AST_WB_UNDER_LOCK: assert property (@(posedge clk) disable iff (rst) (mem_req_valid && mem_req_we) |-> mem_lock); // R9
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> (!rsp_valid && req_ready)); // R10
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst) (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_perm == '0)); // R10
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst) (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0])); // R7

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        req_sum = 1'b0;
  logic        req_mxr = 1'b0;
  logic [21:0] cfg_root_ppn = 22'h000100;
  logic        cfg_hw_ad = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_we;
  logic [33:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_lock;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [33:0] rsp_paddr;
  logic [2:0]  rsp_perm;

  localparam logic [21:0] ROOT = 22'h000100;
  localparam logic [21:0] T2   = 22'h000200;

  typedef struct {
    bit          fault;
    logic [33:0] pa;
    logic [2:0]  perm;
    int          lat;
    int          wb;
    logic [33:0] wb_addr;
    logic [31:0] wb_data;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [31:0] mem [bit [33:0]];

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int acc_cyc = 0;
  int wr_cnt = 0;
  int wr_base = 0;
  int done_cnt = 0;
  bit ended = 1'b0;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_user(req_user), .req_sum(req_sum), .req_mxr(req_mxr),
    .cfg_root_ppn(cfg_root_ppn), .cfg_hw_ad(cfg_hw_ad),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_lock(mem_lock),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic end_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [31:0] rd(input logic [33:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  function automatic logic [31:0] mk(input logic [21:0] ppn, input logic [9:0] flg);
    return {ppn, flg};
  endfunction

  task automatic put(input logic [21:0] tbl, input logic [9:0] idx, input logic [31:0] d);
    mem[{tbl, idx, 2'b00}] = d;
  endtask

  function automatic logic [31:0] va_of(input logic [9:0] hi, input logic [9:0] lo, input logic [11:0] off);
    return {hi, lo, off};
  endfunction

  // expectation built from the requirements
  function automatic exp_t predict(input logic [31:0] va, input logic [1:0] acc,
                                   input bit user, input bit sum, input bit mxr, input bit hw);
    exp_t e;
    logic [33:0] a;
    logic [31:0] p;
    bit top;
    bit go;
    bit ok;
    e.fault = 1'b0; e.pa = '0; e.perm = '0; e.lat = 0; e.wb = 0; e.wb_addr = '0; e.wb_data = '0;
    a = {ROOT, va[31:22], 2'b00};
    top = 1'b1;
    go = 1'b1;
    while (go) begin
      p = rd(a);
      e.lat += 3;
      go = 1'b0;
      if (!p[0] || (!p[1] && p[2])) begin
        e.fault = 1'b1;
      end else if (!p[1] && !p[2] && !p[3]) begin
        if (!top) e.fault = 1'b1;
        else begin
          top = 1'b0;
          a = {p[31:10], va[21:12], 2'b00};
          go = 1'b1;
        end
      end else begin
        case (acc)
          2'd0:    ok = p[1] || (mxr && p[3]);
          2'd1:    ok = p[2];
          2'd2:    ok = p[3];
          default: ok = 1'b0;
        endcase
        if (user && !p[4]) ok = 1'b0;
        if (!user && p[4] && !sum) ok = 1'b0;
        if (top && p[19:10] != 10'h0) ok = 1'b0;
        if (ok && (!p[6] || (acc == 2'd1 && !p[7]))) begin
          if (!hw) ok = 1'b0;
          else begin
            e.wb = 1;
            e.lat += 2;
            e.wb_addr = a;
            e.wb_data = p | 32'h40 | ((acc == 2'd1) ? 32'h80 : 32'h0);
          end
        end
        if (!ok) e.fault = 1'b1;
        else begin
          e.perm = {p[3], p[2], p[1]};
          e.pa = top ? {p[31:20], va[21:0]} : {p[31:10], va[11:0]};
        end
      end
    end
    return e;
  endfunction

  // memory model: answers on the edge after a request pulse
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(posedge clk);
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid) begin
        chk(mem_lock == 1'b1, "R9", "lock during access", 64'(mem_lock), 64'(1));
        if (mem_req_we) begin
          mem[mem_req_addr] = mem_req_wdata;
          wr_cnt++;
        end
        mem_rsp_rdata <= rd(mem_req_addr);
        mem_rsp_valid <= 1'b1;
      end
    end
  end

  // scoreboard monitor
  initial begin
    exp_t  e;
    string t;
    bit    prev_rsp;
    prev_rsp = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_rsp) chk(!rsp_valid, "R10", "response longer than one cycle", 64'(rsp_valid), 64'(0));
      prev_rsp = rsp_valid;
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected response", 64'(1), 64'(0));
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rsp_fault == e.fault, t, "fault", 64'(rsp_fault), 64'(e.fault));
          chk(rsp_paddr == e.pa, t, "paddr", 64'(rsp_paddr), 64'(e.pa));
          chk(rsp_perm == e.perm, t, "perm", 64'(rsp_perm), 64'(e.perm));
          chk((cyc - acc_cyc) == e.lat, "R11", "latency", 64'(cyc - acc_cyc), 64'(e.lat));
          chk((wr_cnt - wr_base) == e.wb, (e.wb != 0) ? "R9" : "R8", "write count",
              64'(wr_cnt - wr_base), 64'(e.wb));
          if (e.wb != 0)
            chk(rd(e.wb_addr) == e.wb_data, "R9", "write-back entry", 64'(rd(e.wb_addr)), 64'(e.wb_data));
        end
        done_cnt++;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input bit user,
                      input bit sum, input bit mxr, input bit hw, input string tag);
    exp_t e;
    int   tgt;
    @(negedge clk);
    tgt = done_cnt + 1;
    e = predict(va, acc, user, sum, mxr, hw);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_vaddr = va; req_acc = acc; req_user = user; req_sum = sum; req_mxr = mxr;
    cfg_hw_ad = hw;
    req_valid = 1'b1;
    @(negedge clk);
    acc_cyc = cyc;
    wr_base = wr_cnt;
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "ready while busy", 64'(req_ready), 64'(0));
    while (done_cnt < tgt) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 64'(done_cnt), 64'(0));
    end_run();
  end

  initial begin
    put(ROOT, 10'd1, mk(T2, 10'h001));
    put(T2, 10'd0, mk(22'h012345, 10'h0C7));
    put(T2, 10'd1, mk(22'h00ABCD, 10'h043));
    put(T2, 10'd2, mk(22'h000777, 10'h0C9));
    put(T2, 10'd3, mk(22'h000555, 10'h0D3));
    put(T2, 10'd4, mk(22'h000111, 10'h0C5));
    put(T2, 10'd5, mk(22'h000222, 10'h0C6));
    put(T2, 10'd6, mk(22'h000300, 10'h001));
    put(T2, 10'd7, mk(22'h003333, 10'h007));
    put(ROOT, 10'd2, mk({12'h0AB, 10'h000}, 10'h0CB));
    put(ROOT, 10'd3, mk({12'h0AC, 10'h001}, 10'h0CB));

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "reset ready", 64'(req_ready), 64'(1));
    chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", 64'(rsp_valid), 64'(0));
    chk(mem_req_valid == 1'b0, "R2", "reset mem_req_valid", 64'(mem_req_valid), 64'(0));
    chk(mem_lock == 1'b0, "R9", "reset lock", 64'(mem_lock), 64'(0));

    walk(va_of(10'd1, 10'd0, 12'h234), 2'd0, 0, 0, 0, 0, "R1");
    walk(va_of(10'd1, 10'd0, 12'hFFC), 2'd1, 0, 0, 0, 0, "R5");
    walk(va_of(10'd1, 10'd0, 12'h010), 2'd2, 0, 0, 0, 0, "R5");
    walk(va_of(10'd1, 10'd2, 12'h100), 2'd0, 0, 0, 0, 0, "R5");
    walk(va_of(10'd1, 10'd2, 12'h104), 2'd0, 0, 0, 1, 0, "R5");
    walk(va_of(10'd1, 10'd2, 12'h108), 2'd2, 0, 0, 0, 0, "R5");
    walk(va_of(10'd1, 10'd2, 12'h10C), 2'd1, 0, 0, 0, 0, "R5");
    walk(va_of(10'd1, 10'd3, 12'h020), 2'd0, 1, 0, 0, 0, "R6");
    walk(va_of(10'd1, 10'd0, 12'h024), 2'd0, 1, 0, 0, 0, "R6");
    walk(va_of(10'd1, 10'd3, 12'h028), 2'd0, 0, 0, 0, 0, "R6");
    walk(va_of(10'd1, 10'd3, 12'h02C), 2'd0, 0, 1, 0, 0, "R6");
    walk(va_of(10'd1, 10'd4, 12'h000), 2'd0, 0, 0, 0, 0, "R3");
    walk(va_of(10'd1, 10'd5, 12'h000), 2'd0, 0, 0, 0, 0, "R3");
    walk(va_of(10'd4, 10'd0, 12'h000), 2'd0, 0, 0, 0, 0, "R3");
    walk(va_of(10'd1, 10'd6, 12'h000), 2'd0, 0, 0, 0, 0, "R4");
    walk(va_of(10'd2, 10'h155, 12'h3A8), 2'd0, 0, 0, 0, 0, "R7");
    walk(va_of(10'd3, 10'h155, 12'h3A8), 2'd0, 0, 0, 0, 0, "R7");
    walk(va_of(10'd1, 10'd1, 12'h040), 2'd1, 0, 0, 0, 0, "R8");
    walk(va_of(10'd1, 10'd7, 12'h044), 2'd0, 0, 0, 0, 0, "R8");
    walk(va_of(10'd1, 10'd7, 12'h048), 2'd0, 0, 0, 0, 1, "R9");
    walk(va_of(10'd1, 10'd7, 12'h04C), 2'd1, 0, 0, 0, 1, "R9");
    walk(va_of(10'd1, 10'd1, 12'h050), 2'd1, 0, 0, 0, 1, "R9");
    walk(va_of(10'd1, 10'd1, 12'h054), 2'd1, 0, 0, 0, 0, "R9");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "responses outstanding", 64'(exp_q.size()), 64'(0));
    end_run();
  end

endmodule